// File: doc/BRIEF.md
# Pipelined Tag Memory with Match Compare

This block is a synchronous tag store for a cache controller. On one rising edge it captures an address, a data word, the chip-select lines and the write controls. On the next edge it either writes the captured word into the array or reads the stored word back. Every read also compares the stored word with the value held in a separate data register. That register loads only when its own enable is low and the device is selected. The compare result passes through one more register, so the match flag follows the read word by one clock.

Writes cover the low 9-bit lane, the high 9-bit lane or both. A global write forces both lanes. Three chip-select lines must all be active to select the device. A deselected or unstrobed cycle releases both outputs after the cycle it occupies, which lets several of these blocks share a bus when stacked in depth. The data output and the match output each have their own active-low enable. Both enables act combinationally. The tristate pins are modelled as a value plus a drive flag.

Top module: `tag_ram_pipe`

## Requirements
- R1: While reset is high and on the first cycle after it, q_oe and match_oe are 0.
- R2: An access is started on an edge where strobe_cpu_n or strobe_ctl_n (or both) is 0. On an edge where both are 1, no access is started, and two edges later q_oe is 0.
- R3: An access needs sel_pipe_n=0, sel_hi=1 and sel_lo_n=0 on the same edge. If any of these is inactive, a write is discarded. The data register also keeps its value in that case. q_oe is 0 after the next edge, and match_oe is 0 one edge after that.
- R4: The data register loads din only on an edge where din_en_n=0 and all three selects are active. A write stores the data register, not din directly.
- R5: With all_wr_n=1 and lane_wr_en_n=0, lane_we_n[0]=0 writes bits 8:0 and lane_we_n[1]=0 writes bits 17:9. With lane_wr_en_n=1, lane_we_n is ignored. With no lane selected, the access is a read.
- R6: all_wr_n=0 writes both lanes, whatever lane_wr_en_n and lane_we_n are. A write access never drives q.
- R7: A read sampled on edge N drives q with the stored word between edges N+1 and N+2, with q_oe=1 when oe_n=0. A read started right after a write to the same address returns the new word.
- R8: Between edges N+2 and N+3, match=1 exactly when the stored word equals the data register as loaded up to edge N, with match_oe=1 when match_oe_n=0.
- R9: oe_n=1 forces q_oe to 0, and match_oe_n=1 forces match_oe to 0, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write and compare data |
| strobe_cpu_n | input | 1 | Address strobe A, active low |
| strobe_ctl_n | input | 1 | Address strobe B, active low |
| sel_pipe_n | input | 1 | Pipeline select, active low |
| sel_hi | input | 1 | Depth select, active high |
| sel_lo_n | input | 1 | Depth select, active low |
| din_en_n | input | 1 | Data register load enable, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_en_n | input | 1 | Per-lane write qualifier, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Data output enable, active low, asynchronous |
| match_oe_n | input | 1 | Match output enable, active low, asynchronous |
| q | output | LANES*LANE_W | Read word |
| q_oe | output | 1 | q is being driven |
| match | output | 1 | Compare result |
| match_oe | output | 1 | match is being driven |

## Verification
The hardest state to reach is a data register whose contents differ from the word just written. Only then does a write store a stale value, or a read compare against an older value. The stimulus gets there with writes issued while din_en_n is high, and with deselected cycles that carry fresh din. It also issues a write followed on the very next edge by a read of the same address, which exercises the read-after-write path. Random reads pick the compare value as the stored word half the time, so both match outcomes occur often.

// File: rtl/tagram_pkg.sv
package tagram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } tag_op_t;

  function automatic logic chip_selected(input logic pipe_n, input logic hi, input logic lo_n);
    return !pipe_n && hi && !lo_n;
  endfunction

endpackage

// File: rtl/tagram_in_regs.sv
module tagram_in_regs
  import tagram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   din,
  input  logic                      strobe_cpu_n,
  input  logic                      strobe_ctl_n,
  input  logic                      sel_pipe_n,
  input  logic                      sel_hi,
  input  logic                      sel_lo_n,
  input  logic                      din_en_n,
  input  logic                      all_wr_n,
  input  logic                      lane_wr_en_n,
  input  logic [LANES-1:0]          lane_we_n,
  output logic [ADDR_W-1:0]         addr_q,
  output logic [LANES*LANE_W-1:0]   din_q,
  output tag_op_t                   op_q,
  output logic [LANES-1:0]          wmask_q
);

  logic             selected;
  logic             strobe;
  logic [LANES-1:0] wmask;

  assign selected = chip_selected(sel_pipe_n, sel_hi, sel_lo_n);
  assign strobe   = !strobe_cpu_n || !strobe_ctl_n;

  always_comb begin
    if (!all_wr_n)          wmask = '1;
    else if (!lane_wr_en_n) wmask = ~lane_we_n;
    else                    wmask = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      din_q   <= '0;
      op_q    <= OP_IDLE;
      wmask_q <= '0;
    end else begin
      if (strobe) addr_q <= addr;
      if (!din_en_n && selected) din_q <= din;
      wmask_q <= wmask;
      if (!(strobe && selected)) op_q <= OP_IDLE;
      else if (|wmask)           op_q <= OP_WRITE;
      else                       op_q <= OP_READ;
    end
  end

endmodule

// File: rtl/tagram_array.sv
module tagram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        wmask,
  input  logic                    rd_en,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_r;

    always_ff @(posedge clk) begin
      if (wmask[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en)    rd_r      <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_r;
  end

endmodule

// File: rtl/tagram_match.sv
module tagram_match #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] din_q,
  input  logic [DATA_W-1:0] rdata,
  output logic              rd_vld,
  output logic              match_r,
  output logic              m_vld
);

  logic [DATA_W-1:0] cmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld  <= 1'b0;
      m_vld   <= 1'b0;
      match_r <= 1'b0;
      cmp_q   <= '0;
    end else begin
      rd_vld  <= rd_en;
      if (rd_en) cmp_q <= din_q;
      m_vld   <= rd_vld;
      match_r <= rd_vld && (rdata == cmp_q);
    end
  end

endmodule

// File: rtl/tag_ram_pipe.sv
module tag_ram_pipe
  import tagram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    strobe_cpu_n,
  input  logic                    strobe_ctl_n,
  input  logic                    sel_pipe_n,
  input  logic                    sel_hi,
  input  logic                    sel_lo_n,
  input  logic                    din_en_n,
  input  logic                    all_wr_n,
  input  logic                    lane_wr_en_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    oe_n,
  input  logic                    match_oe_n,
  output logic [LANES*LANE_W-1:0] q,
  output logic                    q_oe,
  output logic                    match,
  output logic                    match_oe
);

  localparam int DATA_W = LANES * LANE_W;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  tag_op_t           op_q;
  logic [LANES-1:0]  wmask_q;
  logic [LANES-1:0]  wr_lanes;
  logic              rd_en;
  logic [DATA_W-1:0] rdata;
  logic              rd_vld;
  logic              match_r;
  logic              m_vld;

  tagram_in_regs #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
    .clk, .rst, .addr, .din, .strobe_cpu_n, .strobe_ctl_n,
    .sel_pipe_n, .sel_hi, .sel_lo_n, .din_en_n, .all_wr_n,
    .lane_wr_en_n, .lane_we_n,
    .addr_q, .din_q, .op_q, .wmask_q
  );

  assign wr_lanes = (op_q == OP_WRITE) ? wmask_q : '0;
  assign rd_en    = (op_q == OP_READ);

  tagram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk, .addr(addr_q), .wdata(din_q), .wmask(wr_lanes), .rd_en, .rdata
  );

  tagram_match #(.DATA_W(DATA_W)) u_cmp (
    .clk, .rst, .rd_en, .din_q, .rdata, .rd_vld, .match_r, .m_vld
  );

  assign q        = rdata;
  assign q_oe     = rd_vld && !oe_n;
  assign match    = match_r;
  assign match_oe = m_vld && !match_oe_n;

endmodule

// File: rtl/tag_ram_pipe_checker.sv
module tag_ram_pipe_checker #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe_cpu_n,
  input logic              strobe_ctl_n,
  input logic              sel_pipe_n,
  input logic              sel_hi,
  input logic              sel_lo_n,
  input logic              din_en_n,
  input logic              all_wr_n,
  input logic              oe_n,
  input logic              match_oe_n,
  input logic              q_oe,
  input logic              match_oe,
  input logic [DATA_W-1:0] din_q
);

  logic sel_all, strb;
  assign sel_all = !sel_pipe_n && sel_hi && !sel_lo_n;
  assign strb    = !strobe_cpu_n || !strobe_ctl_n;

  assert_no_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !strb |-> ##2 !q_oe);

  assert_deselect_q_R3: assert property (@(posedge clk) disable iff (rst)
    (strb && !sel_all) |-> ##2 !q_oe);

  assert_deselect_match_R3: assert property (@(posedge clk) disable iff (rst)
    (strb && !sel_all) |-> ##3 !match_oe);

  assert_dreg_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (din_en_n || !sel_all) |=> $stable(din_q));

  assert_global_write_silent_R6: assert property (@(posedge clk) disable iff (rst)
    (strb && sel_all && !all_wr_n) |-> ##2 !q_oe);

  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !q_oe);

  assert_moe_gate_R9: assert property (@(posedge clk) disable iff (rst)
    match_oe_n |-> !match_oe);

endmodule

bind tag_ram_pipe tag_ram_pipe_checker #(.DATA_W(LANES*LANE_W)) u_chk (
  .clk, .rst, .strobe_cpu_n, .strobe_ctl_n, .sel_pipe_n, .sel_hi, .sel_lo_n,
  .din_en_n, .all_wr_n, .oe_n, .match_oe_n, .q_oe, .match_oe, .din_q
);

// File: tb/tag_ram_pipe_bench.sv
`timescale 1ns/1ps
module tag_ram_pipe_bench;
  localparam int AW = 6, NL = 2, LW = 9, DW = NL * LW, DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic sp_n, sc_n, cp_n, ch, cl_n, den_n, aw_n, bwe_n, oe_n, moe_n;
  logic [NL-1:0] we_n;
  logic [DW-1:0] q;
  logic q_oe, match, match_oe;

  tag_ram_pipe #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_tag_ram_pipe (
    .clk, .rst, .addr, .din, .strobe_cpu_n(sp_n), .strobe_ctl_n(sc_n),
    .sel_pipe_n(cp_n), .sel_hi(ch), .sel_lo_n(cl_n), .din_en_n(den_n),
    .all_wr_n(aw_n), .lane_wr_en_n(bwe_n), .lane_we_n(we_n),
    .oe_n, .match_oe_n(moe_n), .q, .q_oe, .match, .match_oe
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] mdl [DEPTH];
  logic [DW-1:0] dreg = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_idle();
    sp_n = 1; sc_n = 1; cp_n = 0; ch = 1; cl_n = 0; den_n = 1;
    aw_n = 1; bwe_n = 1; we_n = '1; oe_n = 0; moe_n = 0; addr = '0; din = '0;
  endtask

  function automatic logic [NL-1:0] lanes_of(input logic a, input logic b, input logic [NL-1:0] w);
    if (!a) return '1;
    if (!b) return ~w;
    return '0;
  endfunction

  // Applies stimulus before an edge and updates the bench model; returns the expected outcome.
  task automatic apply(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic dn,
                       input logic s1, input logic s2, input logic c1, input logic c2, input logic c3,
                       input logic a_n, input logic b_n, input logic [NL-1:0] w,
                       output bit is_rd, output logic [DW-1:0] eq, output bit em);
    bit sel, acc;
    logic [NL-1:0] wl;
    addr = a; din = d; den_n = dn; sp_n = s1; sc_n = s2; cp_n = c1; ch = c2; cl_n = c3;
    aw_n = a_n; bwe_n = b_n; we_n = w;
    sel = !c1 && c2 && !c3;
    acc = sel && (!s1 || !s2);
    wl  = lanes_of(a_n, b_n, w);
    if (sel && !dn) dreg = d;
    is_rd = acc && (wl == '0);
    eq = mdl[a];
    em = (mdl[a] == dreg);
    if (acc) for (int l = 0; l < NL; l++)
      if (wl[l]) mdl[a][l*LW +: LW] = dreg[l*LW +: LW];
  endtask

  task automatic access(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic dn,
                        input logic s1, input logic s2, input logic c1, input logic c2, input logic c3,
                        input logic a_n, input logic b_n, input logic [NL-1:0] w, input string tag);
    bit is_rd, em;
    logic [DW-1:0] eq;
    @(negedge clk);
    apply(a, d, dn, s1, s2, c1, c2, c3, a_n, b_n, w, is_rd, eq, em);
    @(negedge clk); set_idle();
    @(negedge clk);
    if (is_rd) begin
      check(q_oe == 1'b1, {tag, " R7 q_oe"}, 32'(q_oe), 1);
      check(q == eq, {tag, " R7 q"}, 32'(q), 32'(eq));
    end else begin
      check(q_oe == 1'b0, {tag, " no-read q_oe"}, 32'(q_oe), 0);
    end
    @(negedge clk);
    if (is_rd) begin
      check(match_oe == 1'b1, {tag, " R8 match_oe"}, 32'(match_oe), 1);
      check(match == em, {tag, " R8 match"}, 32'(match), 32'(em));
    end else begin
      check(match_oe == 1'b0, {tag, " no-read match_oe"}, 32'(match_oe), 0);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] cmpv, input string tag);
    access(a, cmpv, 0, 0, 1, 0, 1, 0, 1, 1, '1, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    bit is_rd, em;
    logic [DW-1:0] eq;
    void'($urandom(32'h1d5e_a7c3));
    set_idle();
    rst = 1;
    repeat (3) @(negedge clk);
    check(q_oe == 0 && match_oe == 0, "R1 during reset", 32'({q_oe, match_oe}), 0);
    rst = 0;
    @(negedge clk);
    check(q_oe == 0 && match_oe == 0, "R1 after reset", 32'({q_oe, match_oe}), 0);

    // R6: fill every word with a global write, lane qualifiers set against it
    for (int i = 0; i < DEPTH; i++)
      access(AW'(i), DW'(i * 1021 + 7), 0, 1, 0, 0, 1, 0, 0, 1, '1, "R6 fill");
    for (int i = 0; i < 4; i++) rd(AW'(i), DW'(i * 1021 + 7), "R6 readback");

    // R2: each strobe alone starts an access; neither does not
    access(6'd9, 18'h0, 0, 0, 1, 0, 1, 0, 1, 1, '1, "R2 cpu strobe");
    access(6'd9, 18'h0, 0, 1, 0, 0, 1, 0, 1, 1, '1, "R2 ctl strobe");
    access(6'd9, 18'h0, 0, 1, 1, 0, 1, 0, 0, 1, '1, "R2 no strobe");
    rd(6'd9, DW'(9 * 1021 + 7), "R2 write without strobe dropped");

    // R5: single-lane writes and ignored lane enables
    access(6'd5, 18'h3_ffff, 0, 0, 1, 0, 1, 0, 1, 0, 2'b10, "R5 low lane");
    rd(6'd5, '0, "R5 low lane readback");
    access(6'd5, 18'h0_0000, 0, 0, 1, 0, 1, 0, 1, 0, 2'b01, "R5 high lane");
    rd(6'd5, 18'h0_01ff, "R5 high lane readback");
    access(6'd5, 18'h1_2345, 0, 0, 1, 0, 1, 0, 1, 1, 2'b00, "R5 qualifier off is read");

    // R4: data register holds while din_en_n is high or while deselected
    rd(6'd7, 18'h2_aaaa, "R4 load dreg");
    access(6'd7, 18'h1_5555, 1, 0, 1, 0, 1, 0, 0, 1, '1, "R4 write stale dreg");
    access(6'd7, 18'h0_f0f0, 0, 0, 1, 1, 1, 0, 1, 1, '1, "R4 R3 deselected load");
    access(6'd7, 18'h0_0000, 1, 0, 1, 0, 1, 0, 1, 1, '1, "R4 compare stale dreg");
    check(mdl[7] == 18'h2_aaaa, "R4 model", 32'(mdl[7]), 32'h2aaaa);

    // R3: each select inactive in turn drops the write
    access(6'd8, 18'h0_0001, 0, 0, 1, 1, 1, 0, 0, 1, '1, "R3 pipe sel");
    access(6'd8, 18'h0_0002, 0, 0, 1, 0, 0, 0, 0, 1, '1, "R3 hi sel");
    access(6'd8, 18'h0_0003, 0, 0, 1, 0, 1, 1, 0, 1, '1, "R3 lo sel");
    rd(6'd8, DW'(8 * 1021 + 7), "R3 word unchanged");

    // R7: write then read of the same address on consecutive edges
    @(negedge clk);
    apply(6'd12, 18'h3_c0de, 0, 0, 1, 0, 1, 0, 0, 1, '1, is_rd, eq, em);
    @(negedge clk);
    apply(6'd12, 18'h3_c0de, 0, 1, 0, 0, 1, 0, 1, 1, '1, is_rd, eq, em);
    @(negedge clk); set_idle();
    @(negedge clk);
    check(q_oe == 1 && q == 18'h3_c0de, "R7 back-to-back q", 32'(q), 32'h3c0de);
    @(negedge clk);
    check(match_oe == 1 && match == 1, "R8 back-to-back match", 32'({match_oe, match}), 3);

    // R9: asynchronous output enables
    @(negedge clk);
    apply(6'd12, 18'h0, 0, 0, 1, 0, 1, 0, 1, 1, '1, is_rd, eq, em);
    @(negedge clk); set_idle();
    @(negedge clk);
    oe_n = 1; #1;
    check(q_oe == 0, "R9 oe_n high", 32'(q_oe), 0);
    oe_n = 0; #1;
    check(q_oe == 1, "R9 oe_n low", 32'(q_oe), 1);
    @(negedge clk);
    moe_n = 1; #1;
    check(match_oe == 0, "R9 match_oe_n high", 32'(match_oe), 0);
    moe_n = 0; #1;
    check(match_oe == 1, "R9 match_oe_n low", 32'(match_oe), 1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      automatic int kind = $urandom % 8;
      automatic logic [AW-1:0] a = AW'($urandom);
      automatic logic [DW-1:0] d = DW'($urandom);
      automatic int sm = $urandom % 3;
      automatic logic s1 = (sm == 1), s2 = (sm == 2);
      case (kind)
        0, 1, 2: access(a, ($urandom % 2) ? mdl[a] : d, 0, s1, s2, 0, 1, 0, 1, 1, '1, "rand R7 R8 read");
        3: access(a, d, 0, s1, s2, 0, 1, 0, 0, 1'($urandom), 2'($urandom), "rand R6 global");
        4: access(a, d, 0, s1, s2, 0, 1, 0, 1, 0, 2'($urandom), "rand R5 lanes");
        5: begin
          automatic int bad = $urandom % 3;
          access(a, d, 1'($urandom), s1, s2, bad == 0, bad != 1, bad == 2, 0, 1, '1, "rand R3 deselect");
        end
        6: access(a, d, 0, 1, 1, 0, 1, 0, 0, 1, '1, "rand R2 no strobe");
        default: access(a, d, 1, s1, s2, 0, 1, 0, 1, 0, 2'($urandom), "rand R4 stale write");
      endcase
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule